// File: doc/BRIEF.md
# Load/Store Lane Alignment and Extension Unit

This block prepares memory requests for a 32-bit core and recovers load results. For each request it adds a base register to a sign-extended offset, clears the low address bits to form the word address, and derives the byte-lane select from the access size and the low address bits. Store data is steered into the selected lanes. Requests whose size code is reserved, or whose address is not a multiple of the access size, produce a fault flag and no bus request.

The request outputs are registered, one cycle behind the inputs. The unit keeps the size, signedness and lane offset of the last issued load. It uses them to cut the addressed byte, halfword or word out of the returned bus word and widen it to 32 bits. The load result is combinational from the returned word.

Top module: `lsu_align`

## Requirements
- R1: One clock edge after a request is presented, an issued request shows `mem_addr_o` equal to `rs1_i + imm_i` (modulo 2^32) with bits [1:0] cleared.
- R2: Byte select (bit n enables data bits [8n+7:8n]): byte access gives 0001 shifted left by addr[1:0], halfword gives 0011 shifted left by 2*addr[1], word gives 1111.
- R3: Store data: size code 0 (byte) repeats wdata[7:0] in all four lanes, code 1 (halfword) repeats wdata[15:0] in both halves, code 2 (word) passes wdata unchanged.
- R4: The load result takes the lanes addressed by the last issued load, shifted down to bit 0. Code 0 gives a sign-extended byte, 1 a sign-extended halfword, 2 the whole word, 4 a zero-extended byte and 5 a zero-extended halfword.
- R5: A halfword with addr[0]=1, or a word with addr[1:0]≠0, raises `misaligned_o` for one cycle with `mem_valid_o` low.
- R6: Reserved codes raise `illegal_o` with `mem_valid_o` low. For loads these are 3, 6 and 7; for stores they are 3 to 7. A reserved code never raises `misaligned_o`.
- R7: While `rst_ni` is low, `mem_valid_o`, `misaligned_o` and `illegal_o` are low, and the load result is zero.
- R8: A cycle with `req_valid_i` low yields `mem_valid_o`, `misaligned_o` and `illegal_o` all low after the next edge.
- R9: On an issued request `mem_we_o` equals the store bit (1 = store) that was presented with it.
- R10: The load context changes only on an issued load. Stores and faulted requests leave the load result unchanged for the same bus word. Before the first issued load the result is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present this cycle |
| req_store_i | input | 1 | 1 = store, 0 = load |
| req_funct3_i | input | 3 | Size/extension code |
| rs1_i | input | 32 | Base address register |
| imm_i | input | 32 | Sign-extended offset |
| wdata_i | input | 32 | Store source data |
| rdata_i | input | 32 | Word returned by memory |
| mem_valid_o | output | 1 | Bus request issued |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 32 | Word-aligned bus address |
| mem_sel_o | output | 4 | Byte-lane select |
| mem_wdata_o | output | 32 | Lane-steered store data |
| misaligned_o | output | 1 | Misaligned access, no request |
| illegal_o | output | 1 | Reserved size code, no request |
| load_data_o | output | 32 | Extracted and extended load result |

## Verification
A wrong lane decode shows in `mem_sel_o` and `mem_wdata_o` on the cycle after the request. A corrupted load context shows in `load_data_o` once the next bus word is applied, and it stays wrong until the next issued load. A fault decode error shows as a request, or a missing request, on the same cycle that `mem_valid_o` would rise. Random sizes, offsets and data are mixed with directed cases at every lane offset, on sign boundaries and on reserved codes.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;
  typedef enum logic [1:0] {SZ_B = 2'd0, SZ_H = 2'd1, SZ_W = 2'd2, SZ_BAD = 2'd3} acc_size_e;

  typedef struct packed {
    acc_size_e size;
    logic      uns;
  } acc_kind_t;

  function automatic acc_kind_t decode_f3(input logic is_store, input logic [2:0] f3);
    acc_kind_t k;
    k = '{size: SZ_BAD, uns: 1'b0};
    case (f3)
      3'd0: k.size = SZ_B;
      3'd1: k.size = SZ_H;
      3'd2: k.size = SZ_W;
      3'd4: if (!is_store) k = '{size: SZ_B, uns: 1'b1};
      3'd5: if (!is_store) k = '{size: SZ_H, uns: 1'b1};
      default: k.size = SZ_BAD;
    endcase
    return k;
  endfunction
endpackage

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen
  import lsu_align_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0]                rs1_i,
  input  logic [XLEN-1:0]                imm_i,
  input  acc_size_e                      size_i,
  output logic [XLEN-1:0]                bus_addr_o,
  output logic [$clog2(XLEN/8)-1:0]      off_o,
  output logic [XLEN/8-1:0]              sel_o,
  output logic                           misaligned_o
);
  localparam int LANES = XLEN / 8;
  localparam int OFF_W = $clog2(LANES);

  logic [XLEN-1:0] eff;
  logic [OFF_W-1:0] off;

  assign eff        = rs1_i + imm_i;
  assign off        = eff[OFF_W-1:0];
  assign off_o      = off;
  assign bus_addr_o = {eff[XLEN-1:OFF_W], {OFF_W{1'b0}}};

  always_comb begin
    sel_o        = '0;
    misaligned_o = 1'b0;
    case (size_i)
      SZ_B: sel_o = {{(LANES-1){1'b0}}, 1'b1} << off;
      SZ_H: begin
        sel_o        = {{(LANES-2){1'b0}}, 2'b11} << {off[OFF_W-1:1], 1'b0};
        misaligned_o = off[0];
      end
      SZ_W: begin
        sel_o        = '1;
        misaligned_o = |off;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/lsu_store_steer.sv
module lsu_store_steer
  import lsu_align_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  acc_size_e       size_i,
  input  logic [XLEN-1:0] data_i,
  output logic [XLEN-1:0] data_o
);
  localparam int LANES = XLEN / 8;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign data_o[8*i +: 8] = (size_i == SZ_B) ? data_i[7:0] :
                              (size_i == SZ_H) ? data_i[8*(i%2) +: 8] :
                                                 data_i[8*i +: 8];
  end
endmodule

// File: rtl/lsu_load_extend.sv
module lsu_load_extend
  import lsu_align_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  acc_size_e                 size_i,
  input  logic                      uns_i,
  input  logic [$clog2(XLEN/8)-1:0] off_i,
  input  logic [XLEN-1:0]           rdata_i,
  output logic [XLEN-1:0]           data_o
);
  localparam int OFF_W = $clog2(XLEN / 8);

  logic [7:0]  b;
  logic [15:0] h;

  assign b = rdata_i[{off_i, 3'b000} +: 8];
  assign h = rdata_i[{off_i[OFF_W-1:1], 4'b0000} +: 16];

  always_comb begin
    case (size_i)
      SZ_B:    data_o = {{(XLEN-8){b[7] & ~uns_i}}, b};
      SZ_H:    data_o = {{(XLEN-16){h[15] & ~uns_i}}, h};
      SZ_W:    data_o = rdata_i;
      default: data_o = '0;
    endcase
  end
endmodule

// File: rtl/lsu_align.sv
module lsu_align
  import lsu_align_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_store_i,
  input  logic [2:0]        req_funct3_i,
  input  logic [XLEN-1:0]   rs1_i,
  input  logic [XLEN-1:0]   imm_i,
  input  logic [XLEN-1:0]   wdata_i,
  input  logic [XLEN-1:0]   rdata_i,
  output logic              mem_valid_o,
  output logic              mem_we_o,
  output logic [XLEN-1:0]   mem_addr_o,
  output logic [XLEN/8-1:0] mem_sel_o,
  output logic [XLEN-1:0]   mem_wdata_o,
  output logic              misaligned_o,
  output logic              illegal_o,
  output logic [XLEN-1:0]   load_data_o
);
  localparam int LANES = XLEN / 8;
  localparam int OFF_W = $clog2(LANES);

  acc_kind_t        kind;
  logic [XLEN-1:0]  bus_addr;
  logic [OFF_W-1:0] off;
  logic [LANES-1:0] sel;
  logic             mis;
  logic [XLEN-1:0]  steered;
  logic             bad_c, mis_c, issue_c;

  acc_size_e        ctx_size;
  logic             ctx_uns;
  logic [OFF_W-1:0] ctx_off;

  assign kind = decode_f3(req_store_i, req_funct3_i);

  lsu_addr_gen #(.XLEN(XLEN)) i_addr_gen (
    .rs1_i       (rs1_i),
    .imm_i       (imm_i),
    .size_i      (kind.size),
    .bus_addr_o  (bus_addr),
    .off_o       (off),
    .sel_o       (sel),
    .misaligned_o(mis)
  );

  lsu_store_steer #(.XLEN(XLEN)) i_store_steer (
    .size_i(kind.size),
    .data_i(wdata_i),
    .data_o(steered)
  );

  // reserved code wins over alignment
  assign bad_c   = req_valid_i && (kind.size == SZ_BAD);
  assign mis_c   = req_valid_i && !bad_c && mis;
  assign issue_c = req_valid_i && !bad_c && !mis;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_valid_o  <= 1'b0;
      misaligned_o <= 1'b0;
      illegal_o    <= 1'b0;
      mem_we_o     <= 1'b0;
      mem_addr_o   <= '0;
      mem_sel_o    <= '0;
      mem_wdata_o  <= '0;
      ctx_size     <= SZ_BAD;
      ctx_uns      <= 1'b0;
      ctx_off      <= '0;
    end else begin
      mem_valid_o  <= issue_c;
      misaligned_o <= mis_c;
      illegal_o    <= bad_c;
      if (issue_c) begin
        mem_we_o    <= req_store_i;
        mem_addr_o  <= bus_addr;
        mem_sel_o   <= sel;
        mem_wdata_o <= steered;
        if (!req_store_i) begin
          ctx_size <= kind.size;
          ctx_uns  <= kind.uns;
          ctx_off  <= off;
        end
      end
    end
  end

  lsu_load_extend #(.XLEN(XLEN)) i_load_extend (
    .size_i (ctx_size),
    .uns_i  (ctx_uns),
    .off_i  (ctx_off),
    .rdata_i(rdata_i),
    .data_o (load_data_o)
  );
endmodule

// File: rtl/lsu_align_chk.sv
module lsu_align_chk #(
  parameter int XLEN = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_store_i,
  input logic [XLEN-1:0]   rs1_i,
  input logic [XLEN-1:0]   imm_i,
  input logic              mem_valid_o,
  input logic              mem_we_o,
  input logic [XLEN-1:0]   mem_addr_o,
  input logic [XLEN/8-1:0] mem_sel_o,
  input logic              misaligned_o,
  input logic              illegal_o
);
  localparam int OFF_W = $clog2(XLEN / 8);

  p_addr_aligned_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o |-> (mem_addr_o[OFF_W-1:0] == '0));

  p_addr_sum_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o |-> (mem_addr_o[XLEN-1:OFF_W] == (($past(rs1_i) + $past(imm_i)) >> OFF_W)));

  p_sel_contig_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o |-> ($countones(mem_sel_o) inside {1, 2, 4}));

  p_mis_no_req_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    misaligned_o |-> !mem_valid_o);

  p_ill_no_req_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mem_valid_o, misaligned_o, illegal_o}));

  p_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !(mem_valid_o || misaligned_o || illegal_o));

  p_we_match_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o |-> (mem_we_o == $past(req_store_i)));
endmodule

bind lsu_align lsu_align_chk #(.XLEN(XLEN)) i_lsu_align_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_store_i (req_store_i),
  .rs1_i       (rs1_i),
  .imm_i       (imm_i),
  .mem_valid_o (mem_valid_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_sel_o   (mem_sel_o),
  .misaligned_o(misaligned_o),
  .illegal_o   (illegal_o)
);

// File: tb/test_lsu_align.sv
module test_lsu_align;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0, req_store_i = 1'b0;
  logic [2:0]  req_funct3_i = '0;
  logic [31:0] rs1_i = '0, imm_i = '0, wdata_i = '0, rdata_i = '0;
  logic        mem_valid_o, mem_we_o, misaligned_o, illegal_o;
  logic [31:0] mem_addr_o, mem_wdata_o, load_data_o;
  logic [3:0]  mem_sel_o;

  int total = 0, bad = 0;
  logic [2:0] ctx_f3 = 3'd3;
  logic [1:0] ctx_off = 2'd0;

  always #10 clk_i = ~clk_i;

  lsu_align i_lsu_align (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic is_bad(input logic st, input logic [2:0] f3);
    return st ? (f3 > 3'd2) : (f3 == 3'd3 || f3 == 3'd6 || f3 == 3'd7);
  endfunction

  function automatic logic is_mis(input logic [2:0] f3, input logic [1:0] a);
    if (f3 == 3'd1 || f3 == 3'd5) return a[0];
    if (f3 == 3'd2) return a != 2'd0;
    return 1'b0;
  endfunction

  function automatic logic [3:0] exp_sel(input logic [2:0] f3, input logic [1:0] a);
    case (f3)
      3'd0, 3'd4: return 4'b0001 << a;
      3'd1, 3'd5: return a[1] ? 4'b1100 : 4'b0011;
      default:    return 4'b1111;
    endcase
  endfunction

  function automatic logic [31:0] exp_wd(input logic [2:0] f3, input logic [31:0] d);
    case (f3)
      3'd0:    return {d[7:0], d[7:0], d[7:0], d[7:0]};
      3'd1:    return {d[15:0], d[15:0]};
      default: return d;
    endcase
  endfunction

  function automatic logic [31:0] exp_ld(input logic [2:0] f3, input logic [1:0] a, input logic [31:0] rd);
    logic [31:0] s;
    s = rd >> (8 * a);
    case (f3)
      3'd0:    return {{24{s[7]}}, s[7:0]};
      3'd1:    return {{16{s[15]}}, s[15:0]};
      3'd2:    return rd;
      3'd4:    return {24'd0, s[7:0]};
      3'd5:    return {16'd0, s[15:0]};
      default: return 32'd0;
    endcase
  endfunction

  task automatic do_req(input logic st, input logic [2:0] f3, input logic [31:0] b,
                        input logic [31:0] im, input logic [31:0] wd, input logic [31:0] rd);
    logic [31:0] ea;
    logic ill, mis, iss;
    ea  = b + im;
    ill = is_bad(st, f3);
    mis = !ill && is_mis(f3, ea[1:0]);
    iss = !ill && !mis;
    req_valid_i = 1'b1; req_store_i = st; req_funct3_i = f3;
    rs1_i = b; imm_i = im; wdata_i = wd;
    @(negedge clk_i);
    req_valid_i = 1'b0; rdata_i = rd;
    #1;
    chk("R6 illegal", {31'd0, illegal_o}, {31'd0, ill});
    chk("R5 misaligned", {31'd0, misaligned_o}, {31'd0, mis});
    chk("R5/R6 valid", {31'd0, mem_valid_o}, {31'd0, iss});
    if (iss) begin
      chk("R1 addr", mem_addr_o, {ea[31:2], 2'b00});
      chk("R2 sel", {28'd0, mem_sel_o}, {28'd0, exp_sel(f3, ea[1:0])});
      chk("R9 we", {31'd0, mem_we_o}, {31'd0, st});
      if (st) chk("R3 wdata", mem_wdata_o, exp_wd(f3, wd));
      else begin ctx_f3 = f3; ctx_off = ea[1:0]; end
    end
    chk("R4/R10 load", load_data_o, exp_ld(ctx_f3, ctx_off, rd));
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd5150));
    repeat (2) @(negedge clk_i);
    rdata_i = 32'hDEAD_BEEF;
    #1;
    chk("R7 reset valid", {31'd0, mem_valid_o}, 32'd0);
    chk("R7 reset flags", {30'd0, misaligned_o, illegal_o}, 32'd0);
    chk("R7 reset load", load_data_o, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // directed
    do_req(1'b1, 3'd0, 32'h1000, 32'h3, 32'h0000_00A5, 32'h0);        // R3 byte lane 3
    do_req(1'b1, 3'd1, 32'h1000, 32'h2, 32'h0000_BEEF, 32'h0);        // R3 half upper
    do_req(1'b1, 3'd2, 32'h2000, 32'hFFFF_FFFC, 32'h1234_5678, 32'h0);// R1 negative offset
    do_req(1'b0, 3'd0, 32'h10, 32'h1, 32'h0, 32'h0000_8000);          // R4 LB sign
    do_req(1'b0, 3'd4, 32'h10, 32'h1, 32'h0, 32'h0000_8000);          // R4 LBU
    do_req(1'b0, 3'd1, 32'h12, 32'h0, 32'h0, 32'h8001_0000);          // R4 LH sign
    do_req(1'b0, 3'd5, 32'h12, 32'h0, 32'h0, 32'h8001_0000);          // R4 LHU
    do_req(1'b0, 3'd1, 32'h11, 32'h0, 32'h0, 32'h8001_0000);          // R5 half misaligned, R10 held
    do_req(1'b0, 3'd2, 32'h12, 32'h0, 32'h0, 32'h8001_0000);          // R5 word misaligned
    do_req(1'b0, 3'd3, 32'h10, 32'h0, 32'h0, 32'h8001_0000);          // R6 reserved load
    do_req(1'b1, 3'd5, 32'h10, 32'h0, 32'h0, 32'h8001_0000);          // R6 reserved store
    do_req(1'b0, 3'd7, 32'h11, 32'h0, 32'h0, 32'h8001_0000);          // R6 not misaligned
    do_req(1'b0, 3'd2, 32'hFFFF_FFFF, 32'h1, 32'h0, 32'hCAFE_F00D);   // R1 wrap
    // R8: idle cycle
    @(negedge clk_i); #1;
    chk("R8 idle", {29'd0, mem_valid_o, misaligned_o, illegal_o}, 32'd0);

    for (int n = 0; n < 400; n++) begin
      logic [31:0] im;
      im = (n % 3 == 0) ? $urandom : {{20{1'b0}}, 12'($urandom)};
      do_req(1'($urandom), 3'($urandom), $urandom, im, $urandom, $urandom);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule